// File: doc/BRIEF.md
# Period-Synchronous Averaging Sample Sequencer

This block paces an external sampling converter so that two winding-current inputs are integrated over exactly one inverter period. A single-cycle request, issued by the period timer at the start of each inverter period, opens a measurement cycle. From then on the sequencer fires conversion starts at a fixed cycle spacing, flips the channel select on every start so that both inputs are sampled evenly across the period, and adds each returned sample into the sum of the channel it came from.

When the last sample of the cycle has been added, a one-cycle done strobe marks both sums as valid. Each sum is the total of N equally spaced samples, which is N times the period average; scaling is left to the consumer. The sums stay put until the next accepted request clears them. A request that arrives while a cycle is still running does not disturb it; it only sets a sticky overrun flag.

The converter side is a plain start/busy/valid handshake. Returned samples carry no ready: the sequencer accepts a sample in any cycle where `conv_valid` is high during a running cycle, so no back-pressure is applied to the converter, and the sums are presented as held values qualified by `done` rather than as a stream that can stall.

Top module: `period_avg_sampler`

## Requirements
- R1: After reset, `conv_start`, `done` and `overrun` are low and both sums are zero.
- R2: A request accepted while idle produces a `conv_start` in the very next cycle, with `conv_chan` = 0 (input A), and both sums read zero in that cycle.
- R3: Within a cycle, successive `conv_start` pulses are exactly SPACING clock cycles apart, exactly 2*SAMPLES_PER_CH of them are issued, and none follow until the next accepted request.
- R4: `conv_chan` alternates 0, 1, 0, 1 over the starts of a cycle, beginning with 0 (0 selects input A, 1 selects input B).
- R5: The k-th sample returned in a cycle (k counted from 0) is added to `sum_a` when k is even and to `sum_b` when k is odd; both sums are cleared when a request is accepted.
- R6: Each sum is SAMPLE_W + log2(SAMPLES_PER_CH) bits wide, so a full cycle of full-scale samples gives the exact total with no wrap.
- R7: `done` is high for exactly one cycle, the cycle after the last sample of the cycle is accepted.
- R8: From `done` until the next accepted request, both sums stay constant.
- R9: A request arriving while a cycle runs is ignored (no restart, no extra starts, sums unaffected) and sets `overrun`, which stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_req | input | 1 | Period-start request pulse |
| conv_start | output | 1 | One-cycle conversion start |
| conv_chan | output | 1 | Converter input select, 0 = A, 1 = B |
| conv_busy | input | 1 | Converter is converting |
| conv_valid | input | 1 | Converter result valid this cycle |
| conv_data | input | SAMPLE_W | Converter result, unsigned |
| sum_a | output | SAMPLE_W+log2(SAMPLES_PER_CH) | Accumulated input A |
| sum_b | output | SAMPLE_W+log2(SAMPLES_PER_CH) | Accumulated input B |
| done | output | 1 | Both sums complete, one cycle |
| overrun | output | 1 | Sticky: request received during a running cycle |

## Verification
The bench builds the block with 12-bit samples, 4 samples per channel and a 24-cycle spacing, against a converter model with a 10-cycle conversion time. The short cycle of 8 conversions lets several complete cycles, a mid-cycle second request and a follow-up cycle after overrun all run quickly, while the 14-bit sums make the full-scale case (4 x 4095 = 16380) land right at the top of the accumulator range, so any lost carry bit shows.

// File: rtl/period_avg_pkg.sv
package period_avg_pkg;
  localparam int NUM_CH = 2;
  typedef enum logic {CH_A = 1'b0, CH_B = 1'b1} chan_e;
endpackage

// File: rtl/avg_start_timer.sv
module avg_start_timer #(
  parameter int SPACING = 192,
  parameter int TOTAL   = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic launch,
  input  logic run,
  output logic start,
  output logic chan
);
  localparam int CNT_W = $clog2(SPACING);
  localparam int ISS_W = $clog2(TOTAL + 1);

  logic [CNT_W-1:0] gap_cnt;
  logic [ISS_W-1:0] issued;

  assign start = run && (gap_cnt == '0) && (issued < ISS_W'(TOTAL));
  assign chan  = issued[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gap_cnt <= '0;
      issued  <= '0;
    end else if (launch) begin
      gap_cnt <= '0;
      issued  <= '0;
    end else if (run) begin
      gap_cnt <= (gap_cnt == CNT_W'(SPACING - 1)) ? '0 : gap_cnt + 1'b1;
      if (start) issued <= issued + 1'b1;
    end
  end

  // R3: a start is never followed by another in the next cycle
  p_start_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !start);
  // R4: consecutive starts of one cycle use opposite inputs
  p_chan_flip_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !launch) |=> (chan != $past(chan)));
endmodule

// File: rtl/avg_channel_acc.sv
module avg_channel_acc #(
  parameter int SAMPLE_W = 12,
  parameter int ACC_W    = 17
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clear,
  input  logic                add,
  input  logic [SAMPLE_W-1:0] sample,
  output logic [ACC_W-1:0]    sum
);
  logic [ACC_W:0] wide;
  assign wide = {1'b0, sum} + (ACC_W + 1)'(sample);

  always_ff @(posedge clk) begin
    if (!rst_n)      sum <= '0;
    else if (clear)  sum <= '0;
    else if (add)    sum <= wide[ACC_W-1:0];
  end

  // R6: an addition never carries out of the accumulator
  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    add |-> !wide[ACC_W]);
endmodule

// File: rtl/period_avg_sampler.sv
module period_avg_sampler #(
  parameter int SAMPLE_W       = 12,
  parameter int SAMPLES_PER_CH = 32,
  parameter int SPACING        = 192,
  localparam int TOTAL = 2 * SAMPLES_PER_CH,
  localparam int ACC_W = SAMPLE_W + $clog2(SAMPLES_PER_CH)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_req,
  output logic                conv_start,
  output logic                conv_chan,
  input  logic                conv_busy,
  input  logic                conv_valid,
  input  logic [SAMPLE_W-1:0] conv_data,
  output logic [ACC_W-1:0]    sum_a,
  output logic [ACC_W-1:0]    sum_b,
  output logic                done,
  output logic                overrun
);
  import period_avg_pkg::*;
  localparam int RET_W = $clog2(TOTAL);

  logic             running;
  logic             launch;
  logic             take;
  logic             last_ret;
  logic [RET_W-1:0] ret_cnt;
  logic [ACC_W-1:0] sums [NUM_CH];

  assign launch   = start_req && !running;
  assign take     = running && conv_valid;
  assign last_ret = take && (ret_cnt == RET_W'(TOTAL - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      running <= 1'b0;
      ret_cnt <= '0;
      done    <= 1'b0;
      overrun <= 1'b0;
    end else begin
      done <= last_ret;
      if (start_req && running) overrun <= 1'b1;
      if (launch) begin
        running <= 1'b1;
        ret_cnt <= '0;
      end else if (take) begin
        ret_cnt <= ret_cnt + 1'b1;
        if (last_ret) running <= 1'b0;
      end
    end
  end

  avg_start_timer #(.SPACING(SPACING), .TOTAL(TOTAL)) u_timer (
    .clk(clk), .rst_n(rst_n), .launch(launch), .run(running),
    .start(conv_start), .chan(conv_chan)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    avg_channel_acc #(.SAMPLE_W(SAMPLE_W), .ACC_W(ACC_W)) u_acc (
      .clk(clk), .rst_n(rst_n), .clear(launch),
      .add(take && (ret_cnt[0] == chan_e'(c))),
      .sample(conv_data), .sum(sums[c])
    );
  end

  assign sum_a = sums[CH_A];
  assign sum_b = sums[CH_B];

  // R2: the first start follows acceptance at once, on input A
  p_first_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(running) |-> (conv_start && conv_chan == 1'b0));
  // R3: no start issued to a converter that is still busy
  p_start_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> !conv_busy);
  // R7: done lasts one cycle
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R8: sums hold while idle
  p_hold_sums_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !$past(running)) |-> ($stable(sum_a) && $stable(sum_b)));
  // R9: overrun is sticky
  p_overrun_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun);
endmodule

// File: tb/period_avg_sampler_tb.sv
module period_avg_sampler_tb;
  localparam int SW  = 12;
  localparam int NPC = 4;
  localparam int SP  = 24;
  localparam int LAT = 10;
  localparam int TOT = 2 * NPC;
  localparam int AW  = SW + $clog2(NPC);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_req = 1'b0;
  logic          conv_start, conv_chan;
  logic          conv_busy = 1'b0, conv_valid = 1'b0;
  logic [SW-1:0] conv_data = '0;
  logic [AW-1:0] sum_a, sum_b;
  logic          done, overrun;

  period_avg_sampler #(.SAMPLE_W(SW), .SAMPLES_PER_CH(NPC), .SPACING(SP)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_req(start_req),
    .conv_start(conv_start), .conv_chan(conv_chan), .conv_busy(conv_busy),
    .conv_valid(conv_valid), .conv_data(conv_data),
    .sum_a(sum_a), .sum_b(sum_b), .done(done), .overrun(overrun)
  );

  always #10 clk = ~clk;

  int n_tests = 0, n_fail = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  logic [SW-1:0] tb_data [TOT];

  // converter model
  int model_idx = 0, lat_cnt = 0, pend = 0;
  always @(posedge clk) begin
    if (!rst_n) begin
      conv_busy <= 1'b0; conv_valid <= 1'b0; lat_cnt <= 0; model_idx <= 0;
    end else begin
      conv_valid <= 1'b0;
      if (conv_start && !conv_busy) begin
        conv_busy <= 1'b1; lat_cnt <= LAT;
        pend <= model_idx % TOT; model_idx <= model_idx + 1;
      end else if (conv_busy) begin
        if (lat_cnt == 1) begin
          conv_busy <= 1'b0; conv_valid <= 1'b1; conv_data <= tb_data[pend];
        end
        lat_cnt <= lat_cnt - 1;
      end
    end
  end

  // monitor
  int n_starts = 0, last_st = 0, bad_sp = 0, bad_ch = 0, last_val = 0, n_done = 0;
  always @(negedge clk) begin
    if (rst_n && conv_start) begin
      if ((n_starts % TOT) != 0 && (cyc - last_st) != SP) bad_sp++;
      if (conv_chan != n_starts[0]) bad_ch++;
      last_st = cyc;
      n_starts++;
    end
    if (rst_n && conv_valid) last_val = cyc;
    if (rst_n && done) n_done++;
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(conv_start == 1'b0, "R1 conv_start", conv_start, 0);
    chk(done == 1'b0, "R1 done", done, 0);
    chk(overrun == 1'b0, "R1 overrun", overrun, 0);
    chk(sum_a == '0, "R1 sum_a", sum_a, 0);
    chk(sum_b == '0, "R1 sum_b", sum_b, 0);
  endtask

  // extra_at > 0: issue a second request that many cycles into the cycle
  task automatic t_cycle(input string tag, input int extra_at);
    int ea = 0, eb = 0, s0, sp0, ch0, d0, t = 0;
    logic [AW-1:0] ha, hb;
    for (int i = 0; i < TOT; i++) begin
      if (i % 2 == 0) ea += tb_data[i]; else eb += tb_data[i];
    end
    s0 = n_starts; sp0 = bad_sp; ch0 = bad_ch; d0 = n_done;
    start_req = 1'b1;
    @(negedge clk);
    start_req = 1'b0;
    chk(conv_start == 1'b1 && conv_chan == 1'b0, {"R2 first start ", tag}, {conv_start, conv_chan}, 2);
    chk(sum_a == '0 && sum_b == '0, {"R5 clear ", tag}, sum_a + sum_b, 0);
    while (!done && t < TOT * SP + LAT + 50) begin
      start_req = (extra_at > 0 && t == extra_at);
      @(negedge clk);
      t++;
    end
    start_req = 1'b0;
    chk(done == 1'b1, {"R7 done seen ", tag}, done, 1);
    chk(cyc - last_val == 1, {"R7 done timing ", tag}, cyc - last_val, 1);
    chk(sum_a == AW'(ea), {"R5 R6 sum_a ", tag}, sum_a, ea);
    chk(sum_b == AW'(eb), {"R5 R6 sum_b ", tag}, sum_b, eb);
    chk(n_starts - s0 == TOT, {"R3 start count ", tag}, n_starts - s0, TOT);
    chk(bad_sp == sp0, {"R3 spacing ", tag}, bad_sp - sp0, 0);
    chk(bad_ch == ch0, {"R4 alternation ", tag}, bad_ch - ch0, 0);
    ha = sum_a; hb = sum_b;
    @(negedge clk);
    chk(done == 1'b0, {"R7 one cycle ", tag}, done, 0);
    repeat (3 * SP) @(negedge clk);
    chk(sum_a == ha && sum_b == hb, {"R8 hold ", tag}, sum_a, ha);
    chk(n_starts - s0 == TOT, {"R3 no extra starts ", tag}, n_starts - s0, TOT);
    chk(n_done - d0 == 1, {"R7 single done ", tag}, n_done - d0, 1);
  endtask

  initial begin
    #(200000 * 20);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    // ramp: distinct values on each input
    for (int i = 0; i < TOT; i++) tb_data[i] = SW'(100 * i + 7);
    t_cycle("ramp", 0);
    chk(overrun == 1'b0, "R9 no overrun on clean cycles", overrun, 0);
    // full scale: 4 x 4095 = 16380 fits 14 bits
    for (int i = 0; i < TOT; i++) tb_data[i] = '1;
    t_cycle("fullscale", 0);
    // input A high, input B low
    for (int i = 0; i < TOT; i++) tb_data[i] = (i % 2 == 0) ? SW'(3000) : SW'(5);
    t_cycle("split", 0);
    // second request mid-cycle: ignored, overrun set
    for (int i = 0; i < TOT; i++) tb_data[i] = SW'(37 * i + 1);
    t_cycle("overrun", 3 * SP + 5);
    chk(overrun == 1'b1, "R9 overrun set", overrun, 1);
    for (int i = 0; i < TOT; i++) tb_data[i] = SW'(4000 - 300 * i);
    t_cycle("after overrun", 0);
    chk(overrun == 1'b1, "R9 overrun sticky", overrun, 1);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule